// File: doc/BRIEF.md
# Routed Periodic Interrupt Timer

This block is a free-running countdown timer that raises a single interrupt and steers it to one of several processor cores. Software programs a 28-bit reload value, turns the count on, optionally turns the interrupt on, and picks a destination. The destination is a core number together with a choice between the normal interrupt line (IRQ) and the fast interrupt line (FIQ) of that core.

While the count is on, the counter steps down once per clock. When it reaches zero it sets a sticky pending flag, pulses a one-cycle event output, reloads itself and keeps going. Software acknowledges the flag, restarts the count, or does both, by writing one-bits into a command word. The command word holds no state.

Access goes through a plain write strobe and a combinational read port. Reset is asynchronous and active-low. Its release is synchronised inside the block.

Top module: `route_timer`

## Requirements
- R1: After reset all three registers read zero, the event output is low, and every IRQ and FIQ output is low.
- R2: The control word at offset 0x34 holds the reload value in bits 27:0, the count-enable in bit 28 and the interrupt-enable in bit 29. Bit 30 reads zero. Bit 31 reads the pending flag, and a write to bit 31 of this word does not set the flag.
- R3: While count-enable is 1, the counter steps down by one per clock. When it is 0 the counter holds, and no expiry, pending or event can arise.
- R4: An expiry occurs when the count is enabled and the counter is zero. The pending flag rises on the same edge as the one-cycle event pulse, whatever the interrupt-enable, and stays set with no further action. Expiries then repeat every reload+1 cycles.
- R5: Writing bit 31 = 1 into the command word at offset 0x38 clears the pending flag.
- R6: Writing bit 30 = 1 into the command word loads the counter from the reload value at once, which restarts the period. The pending flag is left unchanged.
- R7: A single command write with bits 31 and 30 both set clears the flag and restarts the count.
- R8: If a clear arrives on the same edge as an expiry, the pending flag stays set.
- R9: Command-word bits 29:0 have no effect, and the command word reads zero.
- R10: The routing word at offset 0x24 keeps bits 2:0 and reads zero above them. Codes 0 to 3 select the IRQ of core 0 to 3. Codes 4 to 7 select the FIQ of core 0 to 3.
- R11: The selected output carries pending AND interrupt-enable as a level. Every other IRQ and FIQ output stays low.
- R12: Addresses other than 0x24, 0x34 and 0x38 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_o | output | 1 | One-cycle pulse at each expiry |
| irq_o | output | 4 | Normal interrupt line per core |
| fiq_o | output | 4 | Fast interrupt line per core |

## Verification
A software clear and a counter expiry can land on the same clock edge. When they do, the expiry must win, and a bad priority would lose an interrupt without any sign. The bench runs the timer with a short known period, counts edges from the moment it is enabled, and times a clear write so that its edge coincides with a predicted expiry. It then checks that the pending flag and the event pulse are both still visible. A combined clear-and-restart is also issued part-way through a period. The flag must drop at once, and the next expiry must follow a full period after that write rather than at the old schedule.

// File: rtl/route_timer_pkg.sv
package route_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h38;

  // control word fields
  localparam int BIT_TEN  = 28;
  localparam int BIT_IEN  = 29;
  localparam int BIT_PEND = 31;
  // command word fields
  localparam int BIT_RLD  = 30;
  localparam int BIT_CLR  = 31;
endpackage

// File: rtl/rt_rst_sync.sv
module rt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rt_regs.sv
module rt_regs
  import route_timer_pkg::*;
#(
  parameter int CNT_W   = 28,
  parameter int ROUTE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               pend,
  output logic [DATA_W-1:0]  rdata,
  output logic [CNT_W-1:0]   reload_val,
  output logic               tmr_en,
  output logic               int_en,
  output logic [ROUTE_W-1:0] route_code,
  output logic               clr_cmd,
  output logic               rld_cmd
);
  logic               hit_route;
  logic               hit_ctrl;
  logic               hit_cmd;

  logic [CNT_W-1:0]   reload_q, reload_d;
  logic               ten_q, ten_d;
  logic               ien_q, ien_d;
  logic [ROUTE_W-1:0] route_q, route_d;

  // address decode
  always_comb begin
    hit_route = wr_en && (addr == OFS_ROUTE);
    hit_ctrl  = wr_en && (addr == OFS_CTRL);
    hit_cmd   = wr_en && (addr == OFS_CMD);
  end

  // next-state values, used only when the matching enable is high
  always_comb begin
    reload_d = wdata[CNT_W-1:0];
    ten_d    = wdata[BIT_TEN];
    ien_d    = wdata[BIT_IEN];
    route_d  = wdata[ROUTE_W-1:0];
  end

  // the command word keeps no state: its bits turn into single-cycle strobes
  always_comb begin
    clr_cmd = hit_cmd && wdata[BIT_CLR];
    rld_cmd = hit_cmd && wdata[BIT_RLD];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      ten_q    <= 1'b0;
      ien_q    <= 1'b0;
    end else if (hit_ctrl) begin
      reload_q <= reload_d;
      ten_q    <= ten_d;
      ien_q    <= ien_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
    end else if (hit_route) begin
      route_q <= route_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      OFS_ROUTE: rdata[ROUTE_W-1:0] = route_q;
      OFS_CTRL: begin
        rdata[CNT_W-1:0] = reload_q;
        rdata[BIT_TEN]   = ten_q;
        rdata[BIT_IEN]   = ien_q;
        rdata[BIT_PEND]  = pend;
      end
      default: rdata = '0;
    endcase
  end

  assign reload_val = reload_q;
  assign tmr_en     = ten_q;
  assign int_en     = ien_q;
  assign route_code = route_q;
endmodule

// File: rtl/rt_countdown.sv
module rt_countdown #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             clr_cmd,
  input  logic             rld_cmd,
  output logic             expire,
  output logic             pend,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             pend_q, pend_d;
  logic             tick_q;

  always_comb begin
    expire = tmr_en && (cnt_q == '0);
    cnt_en = tmr_en || rld_cmd;
    if (rld_cmd || expire) begin
      cnt_d = reload_val;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    // a fresh expiry outranks a clear on the same edge
    pend_d = expire || (pend_q && !clr_cmd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      tick_q <= expire;
    end
  end

  assign pend = pend_q;
  assign tick = tick_q;
endmodule

// File: rtl/rt_router.sv
module rt_router #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int ROUTE_W   = 3
) (
  input  logic               pend,
  input  logic               int_en,
  input  logic [ROUTE_W-1:0] route_code,
  output logic [NUM_CORES-1:0] irq,
  output logic [NUM_CORES-1:0] fiq
);
  logic              level;
  logic              use_fiq;
  logic [CORE_W-1:0] core_sel;

  always_comb begin
    level    = pend && int_en;
    use_fiq  = route_code[ROUTE_W-1];
    core_sel = route_code[CORE_W-1:0];
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_comb begin
      irq[c] = level && !use_fiq && (core_sel == CORE_W'(c));
      fiq[c] = level &&  use_fiq && (core_sel == CORE_W'(c));
    end
  end
endmodule

// File: rtl/route_timer.sv
module route_timer
  import route_timer_pkg::*;
#(
  parameter int CNT_W     = 28,
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 tick_o,
  output logic [NUM_CORES-1:0] irq_o,
  output logic [NUM_CORES-1:0] fiq_o
);
  localparam int CORE_W  = $clog2(NUM_CORES);
  localparam int ROUTE_W = CORE_W + 1;

  logic               rst_sync_n;
  logic [CNT_W-1:0]   reload_val;
  logic               tmr_en;
  logic               int_en;
  logic [ROUTE_W-1:0] route_code;
  logic               clr_cmd;
  logic               rld_cmd;
  logic               expire;
  logic               pend;
  logic               tick;

  rt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rt_regs #(.CNT_W(CNT_W), .ROUTE_W(ROUTE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .pend       (pend),
    .rdata      (bus_rdata),
    .reload_val (reload_val),
    .tmr_en     (tmr_en),
    .int_en     (int_en),
    .route_code (route_code),
    .clr_cmd    (clr_cmd),
    .rld_cmd    (rld_cmd)
  );

  rt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tmr_en     (tmr_en),
    .reload_val (reload_val),
    .clr_cmd    (clr_cmd),
    .rld_cmd    (rld_cmd),
    .expire     (expire),
    .pend       (pend),
    .tick       (tick)
  );

  rt_router #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .ROUTE_W(ROUTE_W)) u_route (
    .pend       (pend),
    .int_en     (int_en),
    .route_code (route_code),
    .irq        (irq_o),
    .fiq        (fiq_o)
  );

  assign tick_o = tick;
endmodule

// File: rtl/route_timer_chk.sv
module route_timer_chk #(
  parameter int NUM_CORES = 4,
  parameter int ROUTE_W   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pend,
  input logic                 int_en,
  input logic                 tmr_en,
  input logic                 expire,
  input logic                 clr_cmd,
  input logic [ROUTE_W-1:0]   route_code,
  input logic                 tick_o,
  input logic [NUM_CORES-1:0] irq_o,
  input logic [NUM_CORES-1:0] fiq_o
);
  assert_onehot_out_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fiq_o, irq_o}));

  assert_level_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && int_en) |-> ({fiq_o, irq_o} != '0));

  assert_level_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && int_en) |-> ({fiq_o, irq_o} == '0));

  assert_fiq_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    route_code[ROUTE_W-1] |-> (irq_o == '0));

  assert_irq_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !route_code[ROUTE_W-1] |-> (fiq_o == '0));

  assert_tick_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> pend);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_cmd) |=> pend);

  assert_expiry_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (pend && tick_o));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && !expire) |=> !pend);

  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> !tick_o);
endmodule

bind route_timer route_timer_chk #(.NUM_CORES(NUM_CORES), .ROUTE_W(ROUTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .pend       (pend),
  .int_en     (int_en),
  .tmr_en     (tmr_en),
  .expire     (expire),
  .clr_cmd    (clr_cmd),
  .route_code (route_code),
  .tick_o     (tick_o),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o)
);

// File: tb/route_timer_tb.sv
`timescale 1ns/1ps
module route_timer_tb;
  localparam logic [7:0] A_ROUTE = 8'h24;
  localparam logic [7:0] A_CTRL  = 8'h34;
  localparam logic [7:0] A_CMD   = 8'h38;
  localparam logic [7:0] A_HOLE  = 8'h30;
  localparam logic [31:0] TEN    = 32'h1000_0000;
  localparam logic [31:0] IEN    = 32'h2000_0000;
  localparam logic [31:0] CLR    = 32'h8000_0000;
  localparam logic [31:0] RLD    = 32'h4000_0000;
  localparam int N = 5;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick_o;
  logic [3:0]  irq_o;
  logic [3:0]  fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  route_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_o    (tick_o),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic edges(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pend_is(input string req, input logic exp);
    logic [31:0] v;
    rd(A_CTRL, v);
    chk(req, {31'd0, v[31]}, {31'd0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_ROUTE, v); chk("R1 route", v, 0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_CMD, v);   chk("R1 cmd", v, 0);
    chk("R1 outputs", {23'd0, tick_o, fiq_o, irq_o}, 0);
  endtask

  task automatic t_ctrl_rw;
    logic [31:0] v;
    wr(A_CTRL, 32'hCFFF_FFFF);
    rd(A_CTRL, v); chk("R2 bit30/31 not stored", v, 32'h0FFF_FFFF);
    wr(A_CTRL, 32'h2000_0123);
    rd(A_CTRL, v); chk("R2 ien+reload", v, 32'h2000_0123);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_period;
    wr(A_CTRL, N);
    wr(A_CMD, RLD);
    wr(A_CMD, CLR);
    wr(A_CTRL, TEN | N);       // enable edge = 0
    edges(N);
    pend_is("R3 no expiry yet", 1'b0);
    chk("R4 no tick yet", {31'd0, tick_o}, 0);
    edges(1);                  // edge N+1
    pend_is("R4 pend at expiry", 1'b1);
    chk("R4 tick at expiry", {31'd0, tick_o}, 1);
    edges(N);
    chk("R4 tick one cycle", {31'd0, tick_o}, 0);
    pend_is("R4 sticky with ien=0", 1'b1);
    edges(1);                  // edge 2N+2
    chk("R3 second period tick", {31'd0, tick_o}, 1);
  endtask

  task automatic t_clear;
    wr(A_CMD, CLR);            // edge 2N+3
    pend_is("R5 clear", 1'b0);
    edges(N - 1);
    pend_is("R5 stays clear", 1'b0);
    edges(1);                  // edge 3N+3
    pend_is("R4 third expiry", 1'b1);
  endtask

  task automatic t_collide;
    edges(N);
    wr(A_CMD, CLR);            // edge 4N+4, an expiry edge
    pend_is("R8 expiry beats clear", 1'b1);
    chk("R8 tick on collision", {31'd0, tick_o}, 1);
  endtask

  task automatic t_clear_reload;
    edges(2);
    wr(A_CMD, CLR | RLD);      // edge 4N+7, not an expiry
    pend_is("R7 clear part", 1'b0);
    edges(N);
    pend_is("R7 restart skips old expiry", 1'b0);
    edges(1);
    pend_is("R7 restart period", 1'b1);
    chk("R6 tick after restart", {31'd0, tick_o}, 1);
  endtask

  task automatic t_reload_only;
    edges(1);
    wr(A_CMD, RLD);
    pend_is("R6 reload keeps pending", 1'b1);
    edges(N);
    chk("R6 no tick before full period", {31'd0, tick_o}, 0);
    edges(1);
    chk("R6 tick after full period", {31'd0, tick_o}, 1);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    wr(A_CMD, 32'h3FFF_FFFF);
    pend_is("R9 low bits do not clear", 1'b1);
    rd(A_CMD, v); chk("R9 cmd reads zero", v, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(A_CTRL, N);
    wr(A_CMD, CLR);
    edges(20);
    pend_is("R3 disabled no expiry", 1'b0);
    chk("R3 disabled no tick", {31'd0, tick_o}, 0);
    rd(A_CTRL, v); chk("R2 readback", v, N);
  endtask

  task automatic t_route;
    logic [31:0] v;
    wr(A_CTRL, TEN);
    edges(10);
    wr(A_CTRL, IEN);
    rd(A_CTRL, v); chk("R4 pending with ien", v, 32'hA000_0000);
    for (int code = 0; code < 8; code++) begin
      logic [3:0] ei;
      logic [3:0] ef;
      wr(A_ROUTE, 32'hFFFF_FFF8 | code);
      rd(A_ROUTE, v); chk("R10 route readback", v, code);
      ei = (code < 4) ? (4'b1 << code) : 4'b0;
      ef = (code >= 4) ? (4'b1 << (code - 4)) : 4'b0;
      chk("R10 R11 irq", {28'd0, irq_o}, {28'd0, ei});
      chk("R10 R11 fiq", {28'd0, fiq_o}, {28'd0, ef});
    end
  endtask

  task automatic t_gate;
    logic [31:0] v;
    wr(A_CTRL, 0);
    chk("R11 ien off", {24'd0, fiq_o, irq_o}, 0);
    rd(A_CTRL, v); chk("R11 pending kept", v, CLR);
    wr(A_CTRL, IEN);
    chk("R11 ien on", {28'd0, fiq_o}, 32'h8);
    wr(A_CMD, CLR);
    chk("R11 cleared", {24'd0, fiq_o, irq_o}, 0);
  endtask

  task automatic t_hole;
    logic [31:0] v;
    wr(A_HOLE, 32'hFFFF_FFFF);
    rd(A_HOLE, v);  chk("R12 hole reads zero", v, 0);
    rd(A_ROUTE, v); chk("R12 route untouched", v, 7);
    rd(A_CTRL, v);  chk("R12 ctrl untouched", v, IEN);
    chk("R12 no tick", {31'd0, tick_o}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_wr = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    edges(3);
    rst_n = 1'b1;
    edges(4);
    t_reset();
    t_ctrl_rw();
    t_period();
    t_clear();
    t_collide();
    t_clear_reload();
    t_reload_only();
    t_ignored();
    t_disabled();
    t_route();
    t_gate();
    t_hole();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule